// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Stage

This block holds a processor accumulator word together with a one-bit extension flag, and computes the next value of both from a data operand, a narrow input-port byte and a vector of strobe lines. Each strobe line selects one operation. The arithmetic operations are add and increment. The logic operations are AND, complement and clear. A load operation copies the operand. Two rotations pass bits through the extension flag. An input transfer writes the input byte into the low part of the word. Two further strobes act only on the extension flag.

The state is updated on a rising clock edge when exactly one strobe is high. With no strobe high, the state holds. When two or more strobes are high in the same cycle, the block raises an error flag in that cycle and the state holds. The surrounding control logic decides which strobe to raise. The shared bus and the memory are outside this block.

Top module: `acc_alu`

## Requirements
- R1: After reset the accumulator reads 0x0000, the extension flag reads 0 and the error flag is low.
- R2: Strobe bit 0 (add) writes the low 16 bits of accumulator plus operand into the accumulator and the carry out of bit 15 into the extension flag.
- R3: Strobe bit 1 (AND) writes the bitwise AND of accumulator and operand into the accumulator; the extension flag is unchanged.
- R4: Strobe bit 2 (load) copies the operand into the accumulator; the extension flag is unchanged.
- R5: Strobe bit 3 (clear) writes 0x0000 and strobe bit 4 (complement) inverts every accumulator bit; neither changes the extension flag.
- R6: Strobe bit 5 (increment) adds one to the accumulator, wraps from 0xFFFF to 0x0000, and leaves the extension flag unchanged.
- R7: Strobe bit 6 (rotate right) moves each accumulator bit one place toward bit 0, puts the old flag into bit 15 and puts the old bit 0 into the flag.
- R8: Strobe bit 7 (rotate left) moves each accumulator bit one place toward bit 15, puts the old flag into bit 0 and puts the old bit 15 into the flag.
- R9: Strobe bit 8 (input) writes the 8-bit input byte into accumulator bits 7:0 and leaves bits 15:8 and the flag unchanged.
- R10: Strobe bit 9 clears the extension flag and strobe bit 10 inverts it; the accumulator is unchanged.
- R11: With no strobe high, the accumulator and the flag hold their values.
- R12: With two or more strobes high, the error output is high in that same cycle (it is combinational), and the accumulator and the flag hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 11 | One-hot operation strobes, bit positions as in R2 to R10 |
| dr_i | input | 16 | Data operand |
| inr_i | input | 8 | Input-port byte |
| ac_o | output | 16 | Accumulator value |
| e_o | output | 1 | Extension flag |
| err_o | output | 1 | High when more than one strobe is active |

## Verification
Any two strobes can be raised in the same cycle. A pair such as a rotation together with a flag clear would fight over the extension flag. A pair such as an add together with an input transfer would fight over the low byte. The random stimulus sometimes raises two or more distinct strobe bits together, and directed cases do the same. The bench checks that the error output is high in that cycle and that the accumulator and flag read back unchanged on the following cycle. Because every test starts from non-trivial state, a wrongly merged result cannot pass as a hold.

// File: rtl/acc_pkg.sv
package acc_pkg;
   localparam int OP_ADD   = 0;
   localparam int OP_AND   = 1;
   localparam int OP_LOAD  = 2;
   localparam int OP_CLR   = 3;
   localparam int OP_CMPL  = 4;
   localparam int OP_INC   = 5;
   localparam int OP_ROTR  = 6;
   localparam int OP_ROTL  = 7;
   localparam int OP_INP   = 8;
   localparam int OP_CLRE  = 9;
   localparam int OP_CMPE  = 10;
   localparam int NUM_OPS  = 11;
endpackage

// File: rtl/acc_strobe_check.sv
module acc_strobe_check #(
   parameter int N = acc_pkg::NUM_OPS
) (
   input  logic [N-1:0] sel_i,
   output logic         any_o,
   output logic         multi_o
);
   localparam int CNT_W = $clog2(N + 1);

   logic [CNT_W-1:0] cnt;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < N; i++) begin
         cnt = cnt + CNT_W'(sel_i[i]);
      end
   end

   assign any_o   = |sel_i;
   assign multi_o = (cnt > CNT_W'(1));
endmodule

// File: rtl/acc_op_unit.sv
module acc_op_unit
   import acc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int IN_W   = 8
) (
   input  logic [DATA_W-1:0]  ac_i,
   input  logic               e_i,
   input  logic [DATA_W-1:0]  dr_i,
   input  logic [IN_W-1:0]    inr_i,
   input  logic [NUM_OPS-1:0] sel_i,
   output logic [DATA_W-1:0]  ac_nxt_o,
   output logic               e_nxt_o
);
   localparam int SUM_W = DATA_W + 1;

   logic [SUM_W-1:0]  sum;
   logic [DATA_W-1:0] in_word;

   assign sum = {1'b0, ac_i} + {1'b0, dr_i};

   generate
      if (IN_W == DATA_W) begin : g_full_in
         assign in_word = inr_i;
      end else begin : g_part_in
         assign in_word = {ac_i[DATA_W-1:IN_W], inr_i};
      end
   endgenerate

   always_comb begin
      ac_nxt_o = ac_i;
      e_nxt_o  = e_i;
      if (sel_i[OP_ADD]) begin
         ac_nxt_o = sum[DATA_W-1:0];
         e_nxt_o  = sum[DATA_W];
      end
      if (sel_i[OP_AND])  ac_nxt_o = ac_i & dr_i;
      if (sel_i[OP_LOAD]) ac_nxt_o = dr_i;
      if (sel_i[OP_CLR])  ac_nxt_o = '0;
      if (sel_i[OP_CMPL]) ac_nxt_o = ~ac_i;
      if (sel_i[OP_INC])  ac_nxt_o = ac_i + DATA_W'(1);
      if (sel_i[OP_ROTR]) begin
         ac_nxt_o = {e_i, ac_i[DATA_W-1:1]};
         e_nxt_o  = ac_i[0];
      end
      if (sel_i[OP_ROTL]) begin
         ac_nxt_o = {ac_i[DATA_W-2:0], e_i};
         e_nxt_o  = ac_i[DATA_W-1];
      end
      if (sel_i[OP_INP])  ac_nxt_o = in_word;
      if (sel_i[OP_CLRE]) e_nxt_o  = 1'b0;
      if (sel_i[OP_CMPE]) e_nxt_o  = ~e_i;
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int IN_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_OPS-1:0]  strobe_i,
   input  logic [DATA_W-1:0]   dr_i,
   input  logic [IN_W-1:0]     inr_i,
   output logic [DATA_W-1:0]   ac_o,
   output logic                e_o,
   output logic                err_o
);
   localparam int SUM_W = DATA_W + 1;

   generate
      if (IN_W > DATA_W || IN_W < 1) begin : g_bad_in_w
         $error("acc_alu: IN_W must lie between 1 and DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("acc_alu: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] ac_q, ac_nxt;
   logic              e_q, e_nxt;
   logic              any_stb, multi_stb;

   acc_strobe_check #(.N(NUM_OPS)) u_chk (
      .sel_i   (strobe_i),
      .any_o   (any_stb),
      .multi_o (multi_stb)
   );

   acc_op_unit #(.DATA_W(DATA_W), .IN_W(IN_W)) u_ops (
      .ac_i     (ac_q),
      .e_i      (e_q),
      .dr_i     (dr_i),
      .inr_i    (inr_i),
      .sel_i    (strobe_i),
      .ac_nxt_o (ac_nxt),
      .e_nxt_o  (e_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac_q <= '0;
         e_q  <= 1'b0;
      end else if (any_stb && !multi_stb) begin
         ac_q <= ac_nxt;
         e_q  <= e_nxt;
      end
   end

   assign ac_o  = ac_q;
   assign e_o   = e_q;
   assign err_o = multi_stb;

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i == '0) |=> ($stable(ac_o) && $stable(e_o)));

   // R12
   multi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> ($stable(ac_o) && $stable(e_o)));

   // R12
   err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o == ($countones(strobe_i) > 1));

   // R2
   add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i == NUM_OPS'(1 << OP_ADD)) |=>
      ({e_o, ac_o} == ($past({1'b0, ac_o}) + $past({1'b0, dr_i}))));

   // R6
   inc_keeps_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i == NUM_OPS'(1 << OP_INC)) |=> $stable(e_o));

   // R7
   rotr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i == NUM_OPS'(1 << OP_ROTR)) |=>
      ((e_o == $past(ac_o[0])) && (ac_o[DATA_W-1] == $past(e_o))));

   // R8
   rotl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i == NUM_OPS'(1 << OP_ROTL)) |=>
      ((e_o == $past(ac_o[DATA_W-1])) && (ac_o[0] == $past(e_o))));

   // R10
   flag_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((strobe_i == NUM_OPS'(1 << OP_CLRE)) || (strobe_i == NUM_OPS'(1 << OP_CMPE)))
      |=> $stable(ac_o));

   generate
      if (IN_W < DATA_W) begin : g_inp_chk
         // R9
         inp_high_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (strobe_i == NUM_OPS'(1 << OP_INP)) |=>
            ($stable(ac_o[DATA_W-1:IN_W]) && $stable(e_o)));
      end
   endgenerate
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] strobe = '0;
   logic [15:0] dr = '0;
   logic [7:0]  inr = '0;
   logic [15:0] ac;
   logic        e;
   logic        err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   acc_alu u_acc_alu (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (strobe),
      .dr_i     (dr),
      .inr_i    (inr),
      .ac_o     (ac),
      .e_o      (e),
      .err_o    (err)
   );

   function automatic logic [16:0] model(input logic [15:0] a, input logic f,
                                         input logic [15:0] d, input logic [7:0] b,
                                         input logic [10:0] s);
      logic [16:0] r;
      int cnt;
      cnt = 0;
      for (int i = 0; i < 11; i++) if (s[i]) cnt++;
      r = {f, a};
      if (cnt == 1) begin
         case (s)
            11'h001: r = {1'b0, a} + {1'b0, d};
            11'h002: r = {f, a & d};
            11'h004: r = {f, d};
            11'h008: r = {f, 16'h0000};
            11'h010: r = {f, ~a};
            11'h020: r = {f, a + 16'h0001};
            11'h040: r = {a[0], f, a[15:1]};
            11'h080: r = {a[15], a[14:0], f};
            11'h100: r = {f, a[15:8], b};
            11'h200: r = {1'b0, a};
            11'h400: r = {~f, a};
            default: r = {f, a};
         endcase
      end
      return r;
   endfunction

   function automatic string req_of(input logic [10:0] s);
      case (s)
         11'h000: return "R11";
         11'h001: return "R2";
         11'h002: return "R3";
         11'h004: return "R4";
         11'h008: return "R5";
         11'h010: return "R5";
         11'h020: return "R6";
         11'h040: return "R7";
         11'h080: return "R8";
         11'h100: return "R9";
         11'h200: return "R10";
         11'h400: return "R10";
         default: return "R12";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic run_op(input logic [10:0] s, input logic [15:0] d, input logic [7:0] b);
      logic [16:0] exp;
      logic        exp_err;
      int cnt;
      cnt = 0;
      for (int i = 0; i < 11; i++) if (s[i]) cnt++;
      exp_err = (cnt > 1);
      exp = model(ac, e, d, b, s);
      strobe = s;
      dr = d;
      inr = b;
      #1;
      check(err === exp_err, "R12", 32'(err), 32'(exp_err));
      @(negedge clk);
      check({e, ac} === exp, req_of(s), 32'({e, ac}), 32'(exp));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(ac === 16'h0000 && e === 1'b0 && err === 1'b0, "R1",
            32'({err, e, ac}), 32'd0);

      // directed corners
      run_op(11'h004, 16'hFFFF, 8'h00);     // R4 load
      run_op(11'h001, 16'h0001, 8'h00);     // R2 carry into flag, sum 0
      run_op(11'h080, 16'h0000, 8'h00);     // R8 flag into bit 0
      run_op(11'h040, 16'h0000, 8'h00);     // R7
      run_op(11'h004, 16'hFFFF, 8'h00);
      run_op(11'h020, 16'h0000, 8'h00);     // R6 wrap
      run_op(11'h400, 16'h0000, 8'h00);     // R10 complement flag
      run_op(11'h004, 16'hA5C3, 8'h00);
      run_op(11'h100, 16'h0000, 8'h7E);     // R9 low byte only
      run_op(11'h010, 16'h0000, 8'h00);     // R5 complement
      run_op(11'h002, 16'h0FF0, 8'h00);     // R3
      run_op(11'h240, 16'h1234, 8'h00);     // R12 rotate with flag clear
      run_op(11'h101, 16'h1234, 8'h55);     // R12 add with input
      run_op(11'h000, 16'hFFFF, 8'hFF);     // R11 idle
      run_op(11'h200, 16'h0000, 8'h00);     // R10 clear flag
      run_op(11'h008, 16'h0000, 8'h00);     // R5 clear

      for (int k = 0; k < 400; k++) begin
         logic [10:0] s;
         int sel;
         sel = $urandom % 10;
         if (sel == 0) begin
            s = '0;
         end else if (sel == 1) begin
            int a0, a1;
            a0 = $urandom % 11;
            a1 = (a0 + 1 + ($urandom % 10)) % 11;
            s = (11'd1 << a0) | (11'd1 << a1);
         end else begin
            s = 11'd1 << ($urandom % 11);
         end
         run_op(s, 16'($urandom), 8'($urandom));
      end

      strobe = '0;
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule